// File: doc/BRIEF.md
# Programmable Clock Prescaler and Divider Chain

This block derives a slower clock from a master clock through two cascaded stages: a prescaler that divides by 1, 2 or 4, and a 9-bit programmable integer divider whose divisor is the programmed field plus two. The divisor therefore runs from 2 to 513. A whole-chain bypass setting sends the master clock straight to the output and overrides every other setting. Both stages share the master clock domain: the prescaler produces a one-cycle tick that acts as a clock enable for the divider.

Configuration comes from two 9-bit words: a mode word that selects the bypass and prescaler options, and a divisor word. The words are captured only when a load strobe is sampled high. A load also restarts the chain, so the first high phase of the new setting always begins at a known cycle. A second output gates the divided clock with an enable. The enable is sampled only at the start of a high phase, so the gated output never carries a shortened pulse.

Top module: `clkdiv_chain`

## Requirements
- R1: The divider divides by `div_word_i` + 2. Field 0 gives a divisor of 2 and field 511 gives 513. The output period is divisor × prescale master cycles.
- R2: When mode bits 0 and 1 are both 0, the prescaler is active. Mode bit 2 = 1 selects a prescale of 2 and mode bit 2 = 0 selects 4.
- R3: When mode bit 1 = 1 and mode bit 0 = 0, the prescale is 1 and mode bit 2 has no effect.
- R4: When mode bit 0 = 1, `clk_div_o` follows `clk_i`, and the divisor word and mode bits 1 and 2 have no effect. Mode bits 3 to 8 are ignored in every mode.
- R5: Each period starts with a high phase of floor(divisor/2) × prescale master cycles. The low phase fills the rest of the period.
- R6: Both words are captured only at a rising edge where `load_i` is high, and changes at any other time have no effect. The load restarts the chain. `clk_div_o` is low after the load edge and first goes high after the prescale-th rising edge that follows it.
- R7: While `rst_ni` is low, both outputs are low. After reset the configuration is the default: prescaler bypassed and divisor field 0, which gives half the master frequency. The first high phase follows the first rising edge after release.
- R8: `out_en_i` is sampled only at the edge where a high phase begins. In whole-chain bypass this is every edge that is not a load edge. `clk_gated_o` equals `clk_div_o` while the sampled enable is 1 and is low while it is 0. A load or a reset clears the sampled enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for both configuration words and restart of the chain |
| mode_word_i | input | 9 | Bit 0: whole-chain bypass. Bit 1: prescaler bypass. Bit 2: prescale of 2 (1) or 4 (0). Other bits are ignored |
| div_word_i | input | 9 | Divider field; the divisor is this value plus 2 |
| out_en_i | input | 1 | Output enable for the gated clock |
| clk_div_o | output | 1 | Divided clock |
| clk_gated_o | output | 1 | Divided clock gated by the sampled enable |

## Verification
The hardest cases to reach are enable changes that land in the middle of a high phase. A correct design must hold the gated output at its old state until the next phase starts, so such a change shows no visible effect at first. The bench drives the enable at the half-cycle point at chosen sample indices after a load. These indices fall inside the high phase of a divisor-6 setting and inside single cycles of whole-chain bypass. A bench-side model of the sampled enable, updated only at observed rising edges, predicts every gated sample. A second hard case is a word change with no load. The bench makes this change while the chain runs and then checks that the following pulses keep the old period and high time.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned NF_W      = 9;         // divider field width
  localparam int unsigned MODE_W    = 9;         // mode word width
  localparam int unsigned DIVISOR_W = NF_W + 1;  // holds field + 2
  localparam int unsigned PRE_RW    = 3;         // holds prescale up to 4
  localparam int unsigned DIV_OFFSET = 2;

  // mode word bit positions (decoded by cfg register)
  localparam int unsigned MB_CHAIN = 0;
  localparam int unsigned MB_PRE   = 1;
  localparam int unsigned MB_HALF  = 2;

  typedef struct packed {
    logic            chain_bypass;
    logic            pre_bypass;
    logic            pre_half;
    logic [NF_W-1:0] n_field;
  } div_cfg_t;

  localparam div_cfg_t CFG_DEFAULT = '{
    chain_bypass: 1'b0,
    pre_bypass:   1'b1,
    pre_half:     1'b0,
    n_field:      '0
  };

  function automatic logic [DIVISOR_W-1:0] divisor_of(input logic [NF_W-1:0] f);
    return {1'b0, f} + DIVISOR_W'(DIV_OFFSET);
  endfunction

  function automatic logic [DIVISOR_W-1:0] high_len_of(input logic [DIVISOR_W-1:0] d);
    return d >> 1;
  endfunction

  function automatic logic [PRE_RW-1:0] prescale_of(input div_cfg_t c);
    if (c.chain_bypass || c.pre_bypass) return PRE_RW'(1);
    else if (c.pre_half)                return PRE_RW'(2);
    else                                return PRE_RW'(4);
  endfunction

  function automatic div_cfg_t decode_words(input logic [MODE_W-1:0] m,
                                            input logic [NF_W-1:0]   d);
    div_cfg_t c;
    c.chain_bypass = m[MB_CHAIN];
    c.pre_bypass   = m[MB_PRE];
    c.pre_half     = m[MB_HALF];
    c.n_field      = d;
    return c;
  endfunction

endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic [NF_W-1:0]   div_word_i,
  output div_cfg_t          cfg_o
);

  div_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_DEFAULT;
    else if (load_i) cfg_q <= decode_words(mode_word_i, div_word_i);
  end

  assign cfg_o = cfg_q;

  // R6: configuration only changes at a load edge
  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [PRE_RW-1:0] ratio_i,
  output logic              tick_o
);

  logic [PRE_RW-1:0] pre_cnt_q;
  logic              last_slot;

  assign last_slot = (pre_cnt_q == ratio_i - PRE_RW'(1));
  assign tick_o    = last_slot && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_cnt_q <= '0;
    else if (restart_i) pre_cnt_q <= '0;
    else if (last_slot) pre_cnt_q <= '0;
    else                pre_cnt_q <= pre_cnt_q + PRE_RW'(1);
  end

  assert_pre_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt_q < ratio_i);

  // R2: with a prescale above 1, ticks are never back to back
  assert_pre_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ratio_i > PRE_RW'(1)) |=> !tick_o);

endmodule

// File: rtl/clkdiv_divider.sv
module clkdiv_divider
  import clkdiv_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            tick_i,
  input  logic [NF_W-1:0] n_field_i,
  output logic            div_o,
  output logic            rise_evt_o
);

  logic [DIVISOR_W-1:0] n_div, hi_len, cnt_q, cnt_next;
  logic                 wrap;
  logic                 div_q;

  assign n_div    = divisor_of(n_field_i);
  assign hi_len   = high_len_of(n_div);
  assign wrap     = (cnt_q == '0);
  assign cnt_next = wrap ? (n_div - DIVISOR_W'(1)) : (cnt_q - DIVISOR_W'(1));
  assign rise_evt_o = tick_i && wrap && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_next;
      div_q <= (cnt_next >= (n_div - hi_len));
    end
  end

  assign div_o = div_q;

  assert_div_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < n_div);

  // R5: a high phase only begins on a prescaler tick
  assert_rise_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> $past(tick_i));

  // R6: restart forces the output low
  assert_restart_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !div_q);

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic phase_start_i,
  input  logic en_i,
  output logic gate_o
);

  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gate_q <= 1'b0;
    else if (restart_i)     gate_q <= 1'b0;
    else if (phase_start_i) gate_q <= en_i;
  end

  assign gate_o = gate_q;

  // R8: gate opens only at the start of a high phase
  assert_gate_open_at_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> $past(phase_start_i));

  // R8: gate closes only at a phase start or a restart
  assert_gate_close_at_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_q) |-> $past(phase_start_i || restart_i));

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_pkg::*;
#(
  parameter int unsigned MODE_BITS = MODE_W,
  parameter int unsigned FIELD_BITS = NF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [MODE_BITS-1:0]  mode_word_i,
  input  logic [FIELD_BITS-1:0] div_word_i,
  input  logic                  out_en_i,
  output logic                  clk_div_o,
  output logic                  clk_gated_o
);

  div_cfg_t          cfg;
  logic [PRE_RW-1:0] ratio;
  logic              pre_tick;
  logic              div_q;
  logic              div_rise;
  logic              phase_start;
  logic              gate_open;

  clkdiv_cfg_reg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .mode_word_i (MODE_W'(mode_word_i)),
    .div_word_i  (NF_W'(div_word_i)),
    .cfg_o       (cfg)
  );

  assign ratio = prescale_of(cfg);

  clkdiv_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .ratio_i   (ratio),
    .tick_o    (pre_tick)
  );

  clkdiv_divider u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (load_i),
    .tick_i     (pre_tick),
    .n_field_i  (cfg.n_field),
    .div_o      (div_q),
    .rise_evt_o (div_rise)
  );

  // in whole-chain bypass every non-load edge starts a high phase
  assign phase_start = !load_i && (cfg.chain_bypass || div_rise);

  clkdiv_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restart_i     (load_i),
    .phase_start_i (phase_start),
    .en_i          (out_en_i),
    .gate_o        (gate_open)
  );

  assign clk_div_o   = cfg.chain_bypass ? clk_i : div_q;
  assign clk_gated_o = clk_div_o & gate_open;

  // R7: default configuration holds until the first load
  assert_reset_default_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (cfg == CFG_DEFAULT));

endmodule

// File: tb/clkdiv_chain_tb_top.sv
module clkdiv_chain_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [8:0] mode_w = 9'b000000010;
  logic [8:0] div_w = 9'd0;
  logic       en = 1'b0;
  logic       clk_div, clk_gated;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { int hi; int per; string tag; } exp_t;
  exp_t sb_q[$];
  bit   mon_restart = 1'b0;

  clkdiv_chain dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .load_i      (load),
    .mode_word_i (mode_w),
    .div_word_i  (div_w),
    .out_en_i    (en),
    .clk_div_o   (clk_div),
    .clk_gated_o (clk_gated)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int exp_prescale(input logic [8:0] m);
    if (m[0] || m[1]) return 1;
    return m[2] ? 2 : 4;
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_up();
  end

  // monitor: measures each completed pulse of clk_div_o and scores it
  initial begin
    int  cyc = 0, last_rise = 0, hi_cnt = 0, last_hi = 0;
    bit  dp = 1'b0, have_rise = 1'b0, d;
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (mon_restart) begin
        have_rise = 1'b0;
        mon_restart = 1'b0;
      end
      d = clk_div;
      if (!d && dp) last_hi = hi_cnt;
      if (d && !dp) begin
        if (have_rise && sb_q.size() > 0) begin
          e = sb_q.pop_front();
          check((cyc - last_rise) == e.per, {e.tag, " period"}, cyc - last_rise, e.per);
          check(last_hi == e.hi, {e.tag, " R5 high"}, last_hi, e.hi);
        end
        have_rise = 1'b1;
        last_rise = cyc;
        hi_cnt = 0;
      end
      if (d) hi_cnt++;
      dp = d;
      cyc++;
    end
  end

  // driver: load a configuration, check start latency, queue expected pulses
  task automatic run_cfg(input logic [8:0] m, input logic [8:0] f, input int npulses,
                         input string tag);
    int p, n, k;
    exp_t e;
    p = exp_prescale(m);
    n = int'(f) + 2;
    @(negedge clk);
    mode_w = m; div_w = f; load = 1'b1; mon_restart = 1'b1;
    @(posedge clk);
    #1 load = 1'b0;
    for (int i = 0; i < npulses; i++) begin
      e.hi = (n / 2) * p; e.per = n * p; e.tag = tag;
      sb_q.push_back(e);
    end
    k = 0;
    #1 check(clk_div == 1'b0, "R6 low after load", int'(clk_div), 0);
    while (k < 5000) begin
      @(posedge clk);
      #2 k++;
      if (clk_div) break;
    end
    check(k == p, "R6 first rise latency", k, p);
    while (sb_q.size() != 0) @(posedge clk);
  endtask

  // gated-output run with a bench model of the sampled enable
  task automatic gate_run(input logic [8:0] m, input logic [8:0] f, input int nsamp,
                          input int t_on, input int t_off);
    bit gb = 1'b0, dp = 1'b0, d;
    @(negedge clk);
    mode_w = m; div_w = f; en = 1'b0; load = 1'b1; mon_restart = 1'b1;
    @(posedge clk);
    #1 load = 1'b0;
    for (int i = 1; i <= nsamp; i++) begin
      @(posedge clk);
      #2;
      d = clk_div;
      if (m[0]) gb = en;
      else if (d && !dp) gb = en;
      check(clk_gated == (d & gb), "R8 gated follows sampled enable",
            int'(clk_gated), int'(d & gb));
      dp = d;
      #3;
      if (i == t_on)  en = 1'b1;
      if (i == t_off) en = 1'b0;
      #2;
      if (m[0]) check(clk_gated == 1'b0, "R8 bypass gated low phase", int'(clk_gated), 0);
    end
  endtask

  initial begin
    exp_t e;
    int k;
    // R7: outputs low in reset
    repeat (3) @(posedge clk);
    #2;
    check(clk_div == 1'b0, "R7 div low in reset", int'(clk_div), 0);
    check(clk_gated == 1'b0, "R7 gated low in reset", int'(clk_gated), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_restart = 1'b1;
    for (int i = 0; i < 3; i++) begin
      e.hi = 1; e.per = 2; e.tag = "R7 default half rate";
      sb_q.push_back(e);
    end
    k = 0;
    while (k < 100) begin
      @(posedge clk);
      #2 k++;
      if (clk_div) break;
    end
    check(k == 1, "R7 first rise after release", k, 1);
    while (sb_q.size() != 0) @(posedge clk);

    // R1 and R2 and R3 across divisors and prescales
    run_cfg(9'b000000010, 9'd3,   3, "R1 N=5 P=1");
    run_cfg(9'b000000000, 9'd5,   3, "R2 N=7 P=4");
    run_cfg(9'b000000100, 9'd0,   3, "R2 N=2 P=2");
    run_cfg(9'b000000110, 9'd1,   3, "R3 bit2 ignored N=3");
    run_cfg(9'b000000010, 9'd511, 2, "R1 N=513 P=1");
    run_cfg(9'b000000000, 9'd511, 2, "R1 N=513 P=4");
    run_cfg(9'b111111000, 9'd2,   2, "R4 upper bits ignored N=4 P=4");

    // R6: word changes without load have no effect
    run_cfg(9'b000000010, 9'd3, 1, "R6 base N=5");
    @(negedge clk);
    mode_w = 9'b000000000; div_w = 9'h0F0;
    for (int i = 0; i < 3; i++) begin
      e.hi = 2; e.per = 5; e.tag = "R6 no load keeps N=5";
      sb_q.push_back(e);
    end
    while (sb_q.size() != 0) @(posedge clk);

    // R4: whole-chain bypass passes the master clock
    @(negedge clk);
    mode_w = 9'b000000001; div_w = 9'h155; load = 1'b1; mon_restart = 1'b1;
    @(posedge clk);
    #1 load = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #2 check(clk_div == 1'b1, "R4 bypass high phase", int'(clk_div), 1);
      #5 check(clk_div == 1'b0, "R4 bypass low phase", int'(clk_div), 0);
    end

    // R8: enable changes mid high phase
    gate_run(9'b000000010, 9'd4, 24, 2, 8);
    gate_run(9'b000000001, 9'd7, 8, 2, 5);

    finish_up();
  end

endmodule